// File: doc/BRIEF.md
# Dual-Port Interleaved Banked Data Array

This block is the storage array of a first-level data cache. It is split into four banks, each a synchronous single-port RAM able to do one read or one write per clock. Two request ports feed the array, and the block can take one access from each port in the same clock when the two accesses fall in different banks. Tags, miss handling and refill belong to other blocks. Here the array is plain word storage addressed by byte address.

A 64-byte block is the unit of interleaving. The bank is the block number modulo four, so a linear walk through memory visits the banks in turn. When both ports hit the same bank in one cycle, port 0 is served and port 1 sees its ready low. Port 1 holds its request and is served on a later cycle. Read data comes back one clock after acceptance, on the response port that matches the request port.

Top module: `mbc_interleaved_cache`

## Requirements
- R1: The bank of an access is byte address bits [7:6] (block address = byte address >> 6, modulo 4), so consecutive 64-byte blocks fall in consecutive banks.
- R2: When both ports are valid and their banks differ, both are accepted in the same cycle (req1_ready high).
- R3: When both ports are valid and target the same bank, port 0 is accepted (req0_ready is always high) and req1_ready is low that cycle.
- R4: A read accepted in cycle N gives rspX_valid high with its data in cycle N+1, on the same port, and rspX_valid is low in every cycle that does not follow an accepted read on that port.
- R5: An accepted write stores req_wdata, which a later read of the same word returns. A write produces no response.
- R6: Inside a bank, the storage word is chosen by the address bits above the bank field together with word-offset bits [5:2], so every 32-bit word of every block is held separately.
- R7: While reset is high and in the first cycle after it, both response valids are low.
- R8: If both ports write the same word in the same cycle, port 0's write lands first and port 1's stalled write lands on its retry, so the word ends with port 1's data.
- R9: Byte-offset bits [1:0] do not select storage: addresses that differ only in those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req0_valid | input | 1 | Port 0 request present |
| req0_addr | input | ADDR_W | Port 0 byte address |
| req0_write | input | 1 | Port 0 write (1) or read (0) |
| req0_wdata | input | DATA_W | Port 0 write data |
| req0_ready | output | 1 | Port 0 accepted (always high) |
| req1_valid | input | 1 | Port 1 request present |
| req1_addr | input | ADDR_W | Port 1 byte address |
| req1_write | input | 1 | Port 1 write (1) or read (0) |
| req1_wdata | input | DATA_W | Port 1 write data |
| req1_ready | output | 1 | Port 1 accepted this cycle |
| rsp0_valid | output | 1 | Port 0 read data valid |
| rsp0_rdata | output | DATA_W | Port 0 read data |
| rsp1_valid | output | 1 | Port 1 read data valid |
| rsp1_rdata | output | DATA_W | Port 1 read data |

## Verification
The hardest case to reach is a bank collision where both ports write the very same word, because only the order of the stall and the retry decides which value stays. The bench issues that pair on purpose, holds port 1 through its stall while port 0 stays idle, and then reads the word back. Random pairs over a fully written 1 KiB region then bring in many same-bank collisions that mix reads and writes. A scoreboard checks which port each response arrives on and in which cycle it arrives.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  // which request port drives a bank in a given cycle
  typedef enum logic [0:0] {
    SRC_P0 = 1'b0,
    SRC_P1 = 1'b1
  } mbc_src_e;
endpackage

// File: rtl/mbc_bank.sv
module mbc_bank #(
  parameter int ROW_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      else    rdata    <= mem[row];
    end
  end
endmodule

// File: rtl/mbc_route.sv
module mbc_route #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v0,
  input  logic [BANK_W-1:0]    bank0,
  input  logic                 v1,
  input  logic [BANK_W-1:0]    bank1,
  output logic                 rdy1,
  output logic [NUM_BANKS-1:0] grant0,
  output logic [NUM_BANKS-1:0] grant1
);
  assign rdy1 = !(v0 && (bank0 == bank1));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_grant
    assign grant0[b] = v0 && (bank0 == BANK_W'(b));
    assign grant1[b] = v1 && (bank1 == BANK_W'(b)) && !grant0[b];

    // R8: a bank never takes both ports in one cycle
    a_r8_single_owner: assert property (@(posedge clk) disable iff (rst)
      $onehot0({grant0[b], grant1[b]}));
  end

  // R3: colliding port 1 is held off
  a_r3_conflict_stall: assert property (@(posedge clk) disable iff (rst)
    (v0 && v1 && bank0 == bank1) |-> (!rdy1 && grant1 == '0));

  // R2: distinct banks run in parallel
  a_r2_dual_issue: assert property (@(posedge clk) disable iff (rst)
    (v0 && v1 && bank0 != bank1) |-> (rdy1 && $countones(grant0 | grant1) == 2));

  // R1: each valid port grabs exactly one bank
  a_r1_one_bank: assert property (@(posedge clk) disable iff (rst)
    v0 |-> $countones(grant0) == 1);
endmodule

// File: rtl/mbc_interleaved_cache.sv
module mbc_interleaved_cache
  import mbc_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 64,
  parameter int NUM_BANKS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req0_valid,
  input  logic [ADDR_W-1:0] req0_addr,
  input  logic              req0_write,
  input  logic [DATA_W-1:0] req0_wdata,
  output logic              req0_ready,
  input  logic              req1_valid,
  input  logic [ADDR_W-1:0] req1_addr,
  input  logic              req1_write,
  input  logic [DATA_W-1:0] req1_wdata,
  output logic              req1_ready,
  output logic              rsp0_valid,
  output logic [DATA_W-1:0] rsp0_rdata,
  output logic              rsp1_valid,
  output logic [DATA_W-1:0] rsp1_rdata
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int BLK_SH     = $clog2(BLOCK_BYTES);
  localparam int WIDX_W     = BLK_SH - OFF_W;
  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int HI_LSB     = BLK_SH + BANK_W;
  localparam int ROW_W      = ADDR_W - HI_LSB + WIDX_W;

  // address split
  logic [BANK_W-1:0] bank0, bank1;
  logic [ROW_W-1:0]  row0, row1;
  assign bank0 = req0_addr[HI_LSB-1:BLK_SH];
  assign bank1 = req1_addr[HI_LSB-1:BLK_SH];
  assign row0  = {req0_addr[ADDR_W-1:HI_LSB], req0_addr[BLK_SH-1:OFF_W]};
  assign row1  = {req1_addr[ADDR_W-1:HI_LSB], req1_addr[BLK_SH-1:OFF_W]};

  logic unused_byte_bits;
  assign unused_byte_bits = ^{req0_addr[OFF_W-1:0], req1_addr[OFF_W-1:0]};

  // routing
  logic                 rdy1;
  logic [NUM_BANKS-1:0] grant0, grant1;

  mbc_route #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_route (
    .clk   (clk),
    .rst   (rst),
    .v0    (req0_valid),
    .bank0 (bank0),
    .v1    (req1_valid),
    .bank1 (bank1),
    .rdy1  (rdy1),
    .grant0(grant0),
    .grant1(grant1)
  );

  assign req0_ready = 1'b1;
  assign req1_ready = rdy1;

  // banks
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    mbc_src_e          src;
    logic              b_en, b_we;
    logic [ROW_W-1:0]  b_row;
    logic [DATA_W-1:0] b_wd;

    assign src   = grant1[b] ? SRC_P1 : SRC_P0;
    assign b_en  = grant0[b] | grant1[b];
    assign b_we  = (src == SRC_P1) ? req1_write : req0_write;
    assign b_row = (src == SRC_P1) ? row1       : row0;
    assign b_wd  = (src == SRC_P1) ? req1_wdata : req0_wdata;

    mbc_bank #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_bank (
      .clk  (clk),
      .en   (b_en),
      .we   (b_we),
      .row  (b_row),
      .wdata(b_wd),
      .rdata(bank_rd[b])
    );
  end

  // response tracking
  logic              rd_acc0, rd_acc1;
  logic [BANK_W-1:0] rsp_bank0, rsp_bank1;

  assign rd_acc0 = req0_valid && !req0_write;
  assign rd_acc1 = req1_valid && rdy1 && !req1_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp0_valid <= 1'b0;
      rsp1_valid <= 1'b0;
      rsp_bank0  <= '0;
      rsp_bank1  <= '0;
    end else begin
      rsp0_valid <= rd_acc0;
      rsp1_valid <= rd_acc1;
      rsp_bank0  <= bank0;
      rsp_bank1  <= bank1;
    end
  end

  assign rsp0_rdata = bank_rd[rsp_bank0];
  assign rsp1_rdata = bank_rd[rsp_bank1];

  // R4: accepted reads answer on the next cycle
  a_r4_p0_answer: assert property (@(posedge clk) disable iff (rst)
    (req0_valid && !req0_write) |=> rsp0_valid);
  a_r4_p1_answer: assert property (@(posedge clk) disable iff (rst)
    (req1_valid && req1_ready && !req1_write) |=> rsp1_valid);
  // R4: port 1 stalled means no response next cycle
  a_r4_p1_stall_silent: assert property (@(posedge clk) disable iff (rst)
    (req1_valid && !req1_ready) |=> !rsp1_valid);
  // R5: writes never answer
  a_r5_p0_write_silent: assert property (@(posedge clk) disable iff (rst)
    (req0_valid && req0_write) |=> !rsp0_valid);
endmodule

// File: tb/tb_mbc_interleaved_cache.sv
module tb_mbc_interleaved_cache;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req0_valid = 0, req0_write = 0, req1_valid = 0, req1_write = 0;
  logic [AW-1:0] req0_addr = '0, req1_addr = '0;
  logic [DW-1:0] req0_wdata = '0, req1_wdata = '0;
  logic          req0_ready, req1_ready, rsp0_valid, rsp1_valid;
  logic [DW-1:0] rsp0_rdata, rsp1_rdata;

  always #10 clk = ~clk;  // 50 MHz

  mbc_interleaved_cache dut (
    .clk(clk), .rst(rst),
    .req0_valid(req0_valid), .req0_addr(req0_addr), .req0_write(req0_write),
    .req0_wdata(req0_wdata), .req0_ready(req0_ready),
    .req1_valid(req1_valid), .req1_addr(req1_addr), .req1_write(req1_write),
    .req1_wdata(req1_wdata), .req1_ready(req1_ready),
    .rsp0_valid(rsp0_valid), .rsp0_rdata(rsp0_rdata),
    .rsp1_valid(rsp1_valid), .rsp1_rdata(rsp1_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] model [int];
  logic [DW-1:0] q0 [$];
  logic [DW-1:0] q1 [$];
  bit pend0 = 0, pend1 = 0;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      check(rsp0_valid == pend0, "R4 port0 response timing", 32'(rsp0_valid), 32'(pend0));
      check(rsp1_valid == pend1, "R4 port1 response timing", 32'(rsp1_valid), 32'(pend1));
      if (rsp0_valid) begin
        if (q0.size() == 0) check(0, "R4 port0 unexpected response", rsp0_rdata, 'x);
        else begin
          logic [DW-1:0] e0;
          e0 = q0.pop_front();
          check(rsp0_rdata == e0, "R5 port0 read data", rsp0_rdata, e0);
        end
      end
      if (rsp1_valid) begin
        if (q1.size() == 0) check(0, "R4 port1 unexpected response", rsp1_rdata, 'x);
        else begin
          logic [DW-1:0] e1;
          e1 = q1.pop_front();
          check(rsp1_rdata == e1, "R5 port1 read data", rsp1_rdata, e1);
        end
      end
      pend0 = 0;
      pend1 = 0;
    end
  end

  function automatic int widx(input logic [AW-1:0] a);
    return int'(a >> 2);
  endfunction

  task automatic apply(input bit port, input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
    if (w) model[widx(a)] = d;
    else if (port == 0) begin q0.push_back(model[widx(a)]); pend0 = 1; end
    else begin q1.push_back(model[widx(a)]); pend1 = 1; end
  endtask

  // driver: one pair of requests, port 1 retried until served
  task automatic pair(input bit v0, input bit w0, input logic [AW-1:0] a0,
                      input logic [DW-1:0] d0, input bit v1, input bit w1,
                      input logic [AW-1:0] a1, input logic [DW-1:0] d1);
    bit conflict;
    @(negedge clk);
    req0_valid = v0; req0_write = w0; req0_addr = a0; req0_wdata = d0;
    req1_valid = v1; req1_write = w1; req1_addr = a1; req1_wdata = d1;
    #1;
    // R1: bank is byte address bits [7:6]
    conflict = v0 && v1 && (a0[7:6] == a1[7:6]);
    check(req0_ready == 1'b1, "R3 port0 always ready", 32'(req0_ready), 32'd1);
    if (v1) begin
      if (conflict)
        check(req1_ready == 1'b0, "R3 same-bank stall", 32'(req1_ready), 32'd0);
      else
        check(req1_ready == 1'b1, "R2 parallel accept", 32'(req1_ready), 32'd1);
    end
    @(posedge clk);
    if (v0) apply(0, w0, a0, d0);
    if (v1 && !conflict) apply(1, w1, a1, d1);
    #1;
    req0_valid = 0;
    req1_valid = 0;
    if (conflict) begin
      @(negedge clk);
      req1_valid = 1;
      #1;
      check(req1_ready == 1'b1, "R3 retry accepted", 32'(req1_ready), 32'd1);
      @(posedge clk);
      apply(1, w1, a1, d1);
      #1;
      req1_valid = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    idle(3);
    @(negedge clk);
    check(rsp0_valid == 0 && rsp1_valid == 0, "R7 valids low in reset",
          {30'd0, rsp1_valid, rsp0_valid}, 0);
    rst = 0;
    @(negedge clk);
    check(rsp0_valid == 0 && rsp1_valid == 0, "R7 valids low after reset",
          {30'd0, rsp1_valid, rsp0_valid}, 0);

    // fill region 0..1023: block i on port0, block i+1 on port1 (R1, R2)
    for (int blk = 0; blk < 16; blk += 2)
      for (int w = 0; w < 16; w++)
        pair(1, 1, AW'(blk * 64 + w * 4), 32'h1000_0000 + 32'(blk * 64 + w * 4),
             1, 1, AW'((blk + 1) * 64 + w * 4), 32'h1000_0000 + 32'((blk + 1) * 64 + w * 4));

    // R6: every word offset of a block reads back separately
    for (int w = 0; w < 16; w++)
      pair(1, 0, AW'(128 + w * 4), 0, 1, 0, AW'(192 + w * 4), 0);

    // R6: blocks 0 and 4 share bank 0 but differ in upper bits
    pair(1, 1, 12'h000, 32'hAAAA_0000, 1, 1, 12'h100, 32'hBBBB_0100);
    pair(1, 0, 12'h000, 0, 1, 0, 12'h100, 0);

    // R3: read/read collision, both answered in order
    pair(1, 0, 12'h040, 0, 1, 0, 12'h140, 0);

    // R8: both ports write the same word
    pair(1, 1, 12'h088, 32'hCAFE_0000, 1, 1, 12'h088, 32'hBEEF_0001);
    pair(0, 0, 0, 0, 1, 0, 12'h088, 0);
    idle(2);
    check(model[widx(12'h088)] == 32'hBEEF_0001, "R8 port1 value remains",
          model[widx(12'h088)], 32'hBEEF_0001);

    // R9: byte bits ignored
    pair(1, 1, 12'h0C5, 32'h5555_AAAA, 0, 0, 0, 0);
    pair(1, 0, 12'h0C7, 0, 1, 0, 12'h084, 0);
    check(model[widx(12'h0C4)] == 32'h5555_AAAA, "R9 aliased word",
          model[widx(12'h0C4)], 32'h5555_AAAA);

    // R5: write then read on the other port
    pair(0, 0, 0, 0, 1, 1, 12'h3FC, 32'h1234_5678);
    pair(1, 0, 12'h3FC, 0, 0, 0, 0, 0);

    // random mix inside the written region
    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] ra0, ra1;
      ra0 = AW'($urandom_range(0, 1023));
      ra1 = AW'($urandom_range(0, 1023));
      pair($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ra0, $urandom,
           $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ra1, $urandom);
    end

    idle(3);
    check(q0.size() == 0 && q1.size() == 0, "R4 all reads answered",
          32'(q0.size() + q1.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule